// File: doc/BRIEF.md
# Push-pull serial frame controller

This controller is the host end of a single-wire, two-phase serial bus. A write of one 8-bit word starts an exchange. The block first pushes the word onto the line, least significant bit first, so that a 5-bit data pattern (word bits 4:0) goes out ahead of a 3-bit device address (word bits 7:5). The block then releases the line and samples a 3-bit pull field that the addressed device returns. Last, it checks one end-of-frame bit period.

At the end of the exchange the receive register holds a fixed framing pattern around the three status bits. If the bus misbehaved during the exchange, the register holds all ones instead. A one-cycle `done` pulse marks the moment the register is written. While the exchange runs, `busy` is high. While the pull field is being received, `rx_active` is high. Bit timing comes from a clock-enable divider with `BIT_CYCLES` clocks per bit period.

Top module: `pp_push_pull_ctrl`

## Requirements
- R1: When `wr_en` is high and the controller is idle, the word on `wr_data` is accepted on that clock edge, and `busy` is high from the next cycle until the exchange completes. `busy` is low in the cycle in which `done` is high.
- R2: The push field drives `wr_data` bits 0 through 7 onto `ser_out` in that order, which is data bits 0 to 4 followed by address bits 0 to 2. Each bit is held for one bit period of `BIT_CYCLES` clocks.
- R3: The pull field is three bit periods long, and each bit is sampled at the middle of its period. The first bit received lands in `rx_data[3]`, the second in `rx_data[2]` and the third in `rx_data[1]`.
- R4: A frame that completes without error leaves `rx_data` as 4'b0101 in bits 7:4, the status in bits 3:1 and a 1 in bit 0, with `frame_err` low.
- R5: If `ser_in` differs from the driven bit at the middle of any push bit, the frame ends with `rx_data` equal to 8'hFF and `frame_err` high.
- R6: If `ser_in` is low at the middle of the end-of-frame bit period that follows the pull field, the frame ends with `rx_data` equal to 8'hFF and `frame_err` high.
- R7: `rx_active` is high during exactly the three pull-field bit periods, and low at all other times.
- R8: `done` is a single-cycle pulse that appears 12*`BIT_CYCLES` cycles after the accepting edge, in the same cycle that the new `rx_data` becomes visible.
- R9: A write while `busy` is high is ignored. The frame in progress keeps its line bits and its result, and no second frame follows.
- R10: After reset, `busy`, `rx_active`, `done` and `frame_err` are 0 and `ser_out` is 1. `rx_data` is undefined until the first frame completes.
- R11: `ser_out` is 1 (released) whenever the controller is idle and throughout the pull field and the end-of-frame bit period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the transmit word |
| wr_data | input | 8 | Transmit word: data in bits 4:0, address in bits 7:5 |
| rx_data | output | 8 | Receive register: 0101_sss1, or 8'hFF on error |
| rx_active | output | 1 | High while the pull field is being received |
| busy | output | 1 | High while a frame is in progress |
| done | output | 1 | One-cycle pulse when rx_data is written |
| frame_err | output | 1 | Error result of the last completed frame |
| ser_out | output | 1 | Serial line drive, idle high |
| ser_in | input | 1 | Serial line read-back and pull-field input |

## Verification
The exchange is tried with several transmit words. These include alternating bit patterns, which expose bit-order and address/data swaps, and asymmetric words, which expose a reversed shift. Each word is paired with a different pull pattern, and 3'b100 and 3'b001 in particular separate the first-to-bit-3 mapping from a reversed one. Two error patterns are applied: a single corrupted read-back bit during the push, and a low end-of-frame level. These check that each failure path alone forces 8'hFF. A write issued in the middle of a frame, followed by an idle wait, shows that a busy write neither alters the frame in progress nor queues a second one.

// File: rtl/pp_pkg.sv
package pp_pkg;

    localparam int DATA_BITS = 5;
    localparam int ADDR_BITS = 3;
    localparam int PUSH_BITS = DATA_BITS + ADDR_BITS;
    localparam int PULL_BITS = 3;
    localparam int FRAME_PERIODS = PUSH_BITS + PULL_BITS + 1;

    localparam logic [3:0] RX_HEAD = 4'b0101;
    localparam logic [7:0] RX_ERR  = 8'hFF;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PUSH,
        ST_PULL,
        ST_STOP
    } frame_st_e;

    typedef struct packed {
        logic mid;
        logic bit_end;
    } tick_t;

    function automatic logic [7:0] pack_rx(input logic [PULL_BITS-1:0] st, input logic bad);
        return bad ? RX_ERR : {RX_HEAD, st, 1'b1};
    endfunction

endpackage

// File: rtl/pp_bit_timer.sv
module pp_bit_timer
    import pp_pkg::*;
#(
    parameter int BIT_CYCLES = 8
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  run,
    output tick_t tk
);
    localparam int CNT_W = (BIT_CYCLES > 2) ? $clog2(BIT_CYCLES) : 1;
    localparam logic [CNT_W-1:0] MID  = CNT_W'(BIT_CYCLES / 2);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BIT_CYCLES - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    always_comb begin
        tk.mid     = run && (cnt == MID);
        tk.bit_end = run && (cnt == LAST);
    end
endmodule

// File: rtl/pp_push_shift.sv
module pp_push_shift #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [WIDTH-1:0] load_val,
    input  logic             shift,
    output logic             line_bit
);
    logic [WIDTH-1:0] sr;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr <= '1;
        end else if (load) begin
            sr <= load_val;
        end else if (shift) begin
            sr <= {1'b1, sr[WIDTH-1:1]};
        end
    end

    assign line_bit = sr[0];
endmodule

// File: rtl/pp_pull_capture.sv
module pp_pull_capture #(
    parameter int WIDTH = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             sample,
    input  logic             din,
    output logic [WIDTH-1:0] status
);
    always_ff @(posedge clk) begin
        if (rst || clear) begin
            status <= '0;
        end else if (sample) begin
            status <= {status[WIDTH-2:0], din};
        end
    end
endmodule

// File: rtl/pp_push_pull_ctrl.sv
module pp_push_pull_ctrl
    import pp_pkg::*;
#(
    parameter int BIT_CYCLES = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rx_data,
    output logic       rx_active,
    output logic       busy,
    output logic       done,
    output logic       frame_err,
    output logic       ser_out,
    input  logic       ser_in
);
    localparam int IDX_W = $clog2(PUSH_BITS);
    localparam logic [IDX_W-1:0] PUSH_LAST = IDX_W'(PUSH_BITS - 1);
    localparam logic [IDX_W-1:0] PULL_LAST = IDX_W'(PULL_BITS - 1);

    frame_st_e            state;
    logic [IDX_W-1:0]     bit_idx;
    logic                 bad;
    logic                 bad_now;
    logic                 mismatch;
    logic                 accept;
    logic                 line_bit;
    logic [PULL_BITS-1:0] pull_st;
    logic [7:0]           rx_q;
    tick_t                tk;

    assign accept = wr_en && (state == ST_IDLE);

    pp_bit_timer #(.BIT_CYCLES(BIT_CYCLES)) u_timer (
        .clk (clk),
        .rst (rst),
        .run (state != ST_IDLE),
        .tk  (tk)
    );

    pp_push_shift #(.WIDTH(PUSH_BITS)) u_push (
        .clk      (clk),
        .rst      (rst),
        .load     (accept),
        .load_val (wr_data),
        .shift    ((state == ST_PUSH) && tk.bit_end),
        .line_bit (line_bit)
    );

    pp_pull_capture #(.WIDTH(PULL_BITS)) u_pull (
        .clk    (clk),
        .rst    (rst),
        .clear  (accept),
        .sample ((state == ST_PULL) && tk.mid),
        .din    (ser_in),
        .status (pull_st)
    );

    always_comb begin
        mismatch = 1'b0;
        if (tk.mid) begin
            if (state == ST_PUSH && ser_in != line_bit) mismatch = 1'b1;
            if (state == ST_STOP && !ser_in)            mismatch = 1'b1;
        end
        bad_now = bad || mismatch;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            bit_idx   <= '0;
            bad       <= 1'b0;
            done      <= 1'b0;
            frame_err <= 1'b0;
        end else begin
            done <= 1'b0;
            if (state != ST_IDLE) bad <= bad_now;
            unique case (state)
                ST_IDLE: begin
                    if (accept) begin
                        state   <= ST_PUSH;
                        bit_idx <= '0;
                        bad     <= 1'b0;
                    end
                end
                ST_PUSH: begin
                    if (tk.bit_end) begin
                        if (bit_idx == PUSH_LAST) begin
                            state   <= ST_PULL;
                            bit_idx <= '0;
                        end else begin
                            bit_idx <= bit_idx + 1'b1;
                        end
                    end
                end
                ST_PULL: begin
                    if (tk.bit_end) begin
                        if (bit_idx == PULL_LAST) begin
                            state   <= ST_STOP;
                            bit_idx <= '0;
                        end else begin
                            bit_idx <= bit_idx + 1'b1;
                        end
                    end
                end
                ST_STOP: begin
                    if (tk.bit_end) begin
                        state     <= ST_IDLE;
                        done      <= 1'b1;
                        frame_err <= bad_now;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (state == ST_STOP && tk.bit_end) begin
            rx_q <= pack_rx(pull_st, bad_now);
        end
    end

    assign rx_data   = rx_q;
    assign busy      = (state != ST_IDLE);
    assign rx_active = (state == ST_PULL);
    assign ser_out   = (state == ST_PUSH) ? line_bit : 1'b1;
endmodule

// File: rtl/pp_frame_chk.sv
module pp_frame_chk (
    input logic       clk,
    input logic       rst,
    input logic       wr_en,
    input logic       busy,
    input logic       rx_active,
    input logic       done,
    input logic       frame_err,
    input logic       ser_out,
    input logic [7:0] rx_data
);
    a_r1_accept_sets_busy: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !busy) |=> busy);

    a_r1_done_when_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));

    a_r7_active_within_frame: assert property (@(posedge clk) disable iff (rst)
        rx_active |-> busy);

    a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r4_rx_shape: assert property (@(posedge clk) disable iff (rst)
        (done && !frame_err) |-> (rx_data[7:4] == 4'b0101 && rx_data[0]));

    a_r5_err_all_ones: assert property (@(posedge clk) disable iff (rst)
        (done && frame_err) |-> (rx_data == 8'hFF));

    a_r11_idle_line_high: assert property (@(posedge clk) disable iff (rst)
        (!busy || rx_active) |-> ser_out);

    a_r9_err_moves_with_done: assert property (@(posedge clk) disable iff (rst)
        !$stable(frame_err) |-> done);
endmodule

bind pp_push_pull_ctrl pp_frame_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .busy      (busy),
    .rx_active (rx_active),
    .done      (done),
    .frame_err (frame_err),
    .ser_out   (ser_out),
    .rx_data   (rx_data)
);

// File: tb/tb_pp_push_pull_ctrl.sv
module tb_pp_push_pull_ctrl;
    localparam int B = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rx_data;
    logic       rx_active, busy, done, frame_err, ser_out;
    logic       ser_in;

    int nchecks = 0;
    int nerrors = 0;

    int   tb_cyc = 0;
    logic tb_run = 1'b0;
    int   tb_idx;
    int   cfg_inj = -1;
    logic [2:0] cfg_pull = '0;
    logic cfg_stop = 1'b1;

    always #2.5 clk = ~clk;

    pp_push_pull_ctrl #(.BIT_CYCLES(B)) dut (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .rx_data   (rx_data),
        .rx_active (rx_active),
        .busy      (busy),
        .done      (done),
        .frame_err (frame_err),
        .ser_out   (ser_out),
        .ser_in    (ser_in)
    );

    // Bench-side frame clock: counts cycles since the accepting edge
    always @(posedge clk) begin
        if (rst) begin
            tb_run <= 1'b0;
            tb_cyc <= 0;
        end else if (wr_en && !busy) begin
            tb_run <= 1'b1;
            tb_cyc <= 0;
        end else if (tb_run) begin
            tb_cyc <= tb_cyc + 1;
        end
    end

    assign tb_idx = tb_cyc / B;

    // Device model: echoes the push (optionally corrupted), returns the pull field, then the stop level
    always_comb begin
        ser_in = 1'b1;
        if (tb_run) begin
            if (tb_idx < 8)        ser_in = ser_out ^ (tb_idx == cfg_inj);
            else if (tb_idx == 8)  ser_in = cfg_pull[2];
            else if (tb_idx == 9)  ser_in = cfg_pull[1];
            else if (tb_idx == 10) ser_in = cfg_pull[0];
            else if (tb_idx == 11) ser_in = cfg_stop;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        nchecks++;
        if (!ok) begin
            nerrors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic run_frame(input logic [7:0] word, input logic [2:0] pull,
                             input int inj, input logic stop_lvl,
                             input bit extra_wr, input string req);
        logic [7:0] line;
        logic [7:0] exp_rx;
        logic       exp_bad;
        logic [7:0] rx_seen;
        logic       err_seen;
        bit         got;
        int         done_c;
        int         c;
        line     = '1;
        got      = 1'b0;
        done_c   = -1;
        rx_seen  = '0;
        err_seen = 1'b0;
        cfg_pull = pull;
        cfg_inj  = inj;
        cfg_stop = stop_lvl;
        exp_bad  = (inj >= 0) || !stop_lvl;
        exp_rx   = exp_bad ? 8'hFF : {4'b0101, pull, 1'b1};

        @(negedge clk);
        wr_data = word;
        wr_en   = 1'b1;
        @(negedge clk);
        wr_en   = 1'b0;
        for (int n = 0; n < 14 * B && !got; n++) begin
            c = tb_cyc;
            if (extra_wr && c == 2) begin
                wr_data = ~word;
                wr_en   = 1'b1;
            end
            if (extra_wr && c == 3) wr_en = 1'b0;
            if (c == 0) chk(busy == 1'b1, "R1", "busy after accept", busy, 1);
            for (int i = 0; i < 8; i++)
                if (c == i * B + B / 2) line[i] = ser_out;
            if (c == 8 * B - 1)  chk(rx_active == 1'b0, "R7", "rx_active before pull", rx_active, 0);
            if (c == 8 * B)      chk(rx_active == 1'b1, "R7", "rx_active pull start", rx_active, 1);
            if (c == 11 * B - 1) chk(rx_active == 1'b1, "R7", "rx_active pull end", rx_active, 1);
            if (c == 11 * B)     chk(rx_active == 1'b0, "R7", "rx_active in stop", rx_active, 0);
            if (c == 9 * B)      chk(ser_out == 1'b1, "R11", "line released in pull", ser_out, 1);
            if (done) begin
                got      = 1'b1;
                done_c   = c;
                rx_seen  = rx_data;
                err_seen = frame_err;
                chk(busy == 1'b0, "R1", "busy low at done", busy, 0);
            end else begin
                @(negedge clk);
            end
        end
        chk(got, "R8", "done seen", 32'(got), 1);
        if (got) begin
            chk(done_c == 12 * B, "R8", "done latency", done_c, 12 * B);
            @(negedge clk);
            chk(done == 1'b0, "R8", "done width", done, 0);
            chk(line == word, "R2", "push line order", line, word);
            chk(rx_seen == exp_rx, req, "rx_data", rx_seen, exp_rx);
            chk(err_seen == exp_bad, req, "frame_err", err_seen, exp_bad);
            chk(ser_out == 1'b1, "R11", "line high when idle", ser_out, 1);
        end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(busy == 1'b0,      "R10", "busy reset", busy, 0);
        chk(rx_active == 1'b0, "R10", "rx_active reset", rx_active, 0);
        chk(done == 1'b0,      "R10", "done reset", done, 0);
        chk(frame_err == 1'b0, "R10", "frame_err reset", frame_err, 0);
        chk(ser_out == 1'b1,   "R10", "ser_out reset", ser_out, 1);
    endtask

    task automatic t_valid_patterns();
        run_frame(8'hA5, 3'b101, -1, 1'b1, 1'b0, "R4");
        run_frame(8'h5A, 3'b100, -1, 1'b1, 1'b0, "R3");
        run_frame(8'h1E, 3'b001, -1, 1'b1, 1'b0, "R3");
        run_frame(8'hE0, 3'b000, -1, 1'b1, 1'b0, "R4");
        run_frame(8'h3C, 3'b111, -1, 1'b1, 1'b0, "R4");
    endtask

    task automatic t_push_error();
        run_frame(8'h6B, 3'b010, 6, 1'b1, 1'b0, "R5");
        run_frame(8'h01, 3'b101, 0, 1'b1, 1'b0, "R5");
    endtask

    task automatic t_stop_error();
        run_frame(8'hC3, 3'b011, -1, 1'b0, 1'b0, "R6");
    endtask

    task automatic t_busy_write();
        run_frame(8'h96, 3'b110, -1, 1'b1, 1'b1, "R9");
        repeat (3 * B) @(negedge clk);
        chk(busy == 1'b0, "R9", "no frame from busy write", busy, 0);
        chk(ser_out == 1'b1, "R9", "line idle after busy write", ser_out, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nerrors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrors);
        $finish;
    end

    initial begin
        t_reset();
        t_valid_patterns();
        t_push_error();
        t_stop_error();
        t_busy_write();
        $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrors);
        $finish;
    end
endmodule